// File: doc/BRIEF.md
# PHY Management Register Bridge

This block gives a host access to the registers of an attached Ethernet PHY through a handful of byte-wide local registers. The host writes a PHY register number and, for a write, two data bytes. The block then sends one clause-22 style management frame on a serial clock/data pair and reports progress through a busy flag. For a read, the 16-bit value returned by the PHY is captured into two read-data bytes once the frame ends.

A transaction starts as a side effect of a local register write. Writing the command register with its read bit set starts a read. Writing the high write-data byte starts a write, using the low byte stored earlier. While busy is set, writes to the command and write-data registers are dropped. The frame latches its PHY register number when it starts, so changing the register number during a frame has no effect on that frame.

The management clock is the system clock divided by `2*MDC_HALF`. Every frame carries a 32-bit all-ones preamble and is built for a single, fixed PHY address.

Top module: `mgmt_bridge`

## Requirements
- R1: After reset, every local register reads 0, busy is 0, `mdc_o` is low and `mdio_oe_o` is low.
- R2: A write of the command register (offset 1) with bit 0 = 1 while idle starts a read frame. The frame is sent MSB first: 32 ones, start `01`, opcode `10`, `PHY_ADDR`, the 5-bit register number, then a 2-bit turnaround and 16 data bits. During the turnaround and data bits `mdio_oe_o` is low.
- R3: A write of write-data high (offset 4) while idle starts a write frame: 32 ones, `01`, opcode `01`, `PHY_ADDR`, the register number, turnaround `10`, then the data {high byte, low byte (offset 3)}. `mdio_oe_o` is high for all 64 bits.
- R4: Status (offset 0) bit 0 is busy. It reads 1 in the cycle after the starting write and stays 1 for exactly `128*MDC_HALF` cycles.
- R5: `mdc_o` is low while idle. During a frame it starts low and toggles every `MDC_HALF` cycles. Bit k of the frame is held for cycles `2k*MDC_HALF` to `(2k+2)*MDC_HALF-1` counted from the starting edge, so the data changes only on falling edges of `mdc_o`.
- R6: On a read, `mdio_i` is sampled on the rising `mdc_o` edge of each of the 16 data bits, MSB first. Read-data low (offset 5) and high (offset 6) load together when busy clears after a read. They hold that value across write frames and idle time.
- R7: While busy, writes to command, write-data low and write-data high are ignored: their read-back values do not change and no new frame starts. Clearing the read bit during a read does not stop that read.
- R8: The register number (offset 2, bits 4:0) is writable at any time and reads back; a change during a frame does not alter that frame. Command bit 0 reads back as last written. Offset 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 3 | Host register offset |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the block with `MDC_HALF = 2` and `PHY_ADDR = 5'h05`. A full frame then takes 256 cycles, so several reads and writes fit in the run. These include transfers of all-zero and all-one data, and accesses made in the middle of a frame. With the short divider, the per-cycle check of `mdc_o`, `mdio_oe_o` and `mdio_o` covers every bit boundary of each frame. The PHY register number is also moved while a frame is on the wire, so the check shows that the latched frame does not change.

// File: rtl/mgmt_bridge_pkg.sv
package mgmt_bridge_pkg;
  localparam int HOST_AW   = 3;
  localparam int PHY_AW    = 5;
  localparam int REG_AW    = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_BITS  = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int TA_POS    = PRE_BITS + 2 + 2 + PHY_AW + REG_AW;
  localparam int DATA_POS  = TA_POS + 2;
  localparam int IDX_W     = $clog2(FRAME_BITS);

  typedef enum logic [HOST_AW-1:0] {
    OFS_STATUS = 3'd0,
    OFS_CMD    = 3'd1,
    OFS_PHYREG = 3'd2,
    OFS_WLO    = 3'd3,
    OFS_WHI    = 3'd4,
    OFS_RLO    = 3'd5,
    OFS_RHI    = 3'd6
  } host_ofs_e;
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int MDC_HALF = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(MDC_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = wrap & ~mdc_q;
  assign fall_o = wrap & mdc_q;
endmodule

// File: rtl/mgmt_mdio_seq.sv
module mgmt_mdio_seq
  import mgmt_bridge_pkg::*;
#(
  parameter logic [PHY_AW-1:0] PHY_ADDR = 5'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_rd_i,
  input  logic [REG_AW-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

  logic                  busy_q;
  logic                  rd_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [DATA_W-1:0]     cap_q;
  logic [FRAME_BITS-1:0] frame;
  logic                  last_bit;

  always_comb begin
    frame = {{PRE_BITS{1'b1}}, 2'b01,
             (op_rd_i ? 2'b10 : 2'b01),
             PHY_ADDR, reg_i,
             (op_rd_i ? 2'b11 : 2'b10),
             (op_rd_i ? {DATA_W{1'b1}} : wdata_i)};
  end

  assign last_bit = busy_q && fall_i && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '1;
      cap_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        rd_q   <= op_rd_i;
        idx_q  <= '0;
        sh_q   <= frame;
      end
    end else begin
      if (rise_i && rd_q && (idx_q >= DAT_IDX))
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          sh_q   <= '1;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign mdio_o    = sh_q[FRAME_BITS-1];
  assign mdio_oe_o = busy_q && !(rd_q && (idx_q >= TA_IDX));
  assign rd_done_o = last_bit && rd_q;
  assign rdata_o   = cap_q;
endmodule

// File: rtl/mgmt_host_regs.sv
module mgmt_host_regs
  import mgmt_bridge_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               busy_i,
  input  logic               rd_done_i,
  input  logic [DATA_W-1:0]  capture_i,
  output logic               start_o,
  output logic               op_rd_o,
  output logic               cmd_rd_o,
  output logic [REG_AW-1:0]  phy_reg_o,
  output logic [DATA_W-1:0]  wdata_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic              cmd_rd_q;
  logic [REG_AW-1:0] phy_reg_q;
  logic [7:0]        wlo_q, whi_q;
  logic [DATA_W-1:0] rdata_q;
  logic              wr_cmd, wr_wlo, wr_whi, go_rd, go_wr;

  assign wr_cmd = we_i && !busy_i && (addr_i == OFS_CMD);
  assign wr_wlo = we_i && !busy_i && (addr_i == OFS_WLO);
  assign wr_whi = we_i && !busy_i && (addr_i == OFS_WHI);
  assign go_rd  = wr_cmd && wdata_i[0];
  assign go_wr  = wr_whi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_rd_q  <= 1'b0;
      phy_reg_q <= '0;
      wlo_q     <= '0;
      whi_q     <= '0;
      rdata_q   <= '0;
    end else begin
      if (we_i && (addr_i == OFS_PHYREG)) phy_reg_q <= wdata_i[REG_AW-1:0];
      if (wr_cmd) cmd_rd_q <= wdata_i[0];
      if (wr_wlo) wlo_q <= wdata_i;
      if (wr_whi) whi_q <= wdata_i;
      if (rd_done_i) rdata_q <= capture_i;
    end
  end

  assign start_o   = go_rd | go_wr;
  assign op_rd_o   = go_rd;
  assign cmd_rd_o  = cmd_rd_q;
  assign phy_reg_o = phy_reg_q;
  // write frame takes the new high byte in the same cycle it is stored
  assign wdata_o   = {(go_wr ? wdata_i : whi_q), wlo_q};
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/mgmt_bridge.sv
module mgmt_bridge
  import mgmt_bridge_pkg::*;
#(
  parameter logic [PHY_AW-1:0] PHY_ADDR = 5'd1,
  parameter int                MDC_HALF = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [HOST_AW-1:0] reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  output logic               mdc_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  input  logic               mdio_i
);
  logic              busy, start, op_rd, cmd_rd, rise, fall, rd_done;
  logic [REG_AW-1:0] phy_reg;
  logic [DATA_W-1:0] wdata16, rdata16, capture;

  mgmt_host_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .busy_i    (busy),
    .rd_done_i (rd_done),
    .capture_i (capture),
    .start_o   (start),
    .op_rd_o   (op_rd),
    .cmd_rd_o  (cmd_rd),
    .phy_reg_o (phy_reg),
    .wdata_o   (wdata16),
    .rdata_o   (rdata16)
  );

  mgmt_mdc_gen #(.MDC_HALF(MDC_HALF)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mgmt_mdio_seq #(.PHY_ADDR(PHY_ADDR)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .op_rd_i   (op_rd),
    .reg_i     (phy_reg),
    .wdata_i   (wdata16),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rd_done_o (rd_done),
    .rdata_o   (capture)
  );

  always_comb begin
    unique case (reg_addr_i)
      OFS_STATUS: reg_rdata_o = {7'd0, busy};
      OFS_CMD:    reg_rdata_o = {7'd0, cmd_rd};
      OFS_PHYREG: reg_rdata_o = {{(8-REG_AW){1'b0}}, phy_reg};
      OFS_WLO:    reg_rdata_o = wdata16[7:0];
      OFS_WHI:    reg_rdata_o = wdata16[15:8];
      OFS_RLO:    reg_rdata_o = rdata16[7:0];
      OFS_RHI:    reg_rdata_o = rdata16[15:8];
      default:    reg_rdata_o = 8'd0;
    endcase
  end
endmodule

// File: rtl/mgmt_bridge_chk.sv
module mgmt_bridge_chk
  import mgmt_bridge_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [HOST_AW-1:0] reg_addr_i,
  input logic               mdc_o,
  input logic               mdio_o,
  input logic               mdio_oe_o,
  input logic               busy,
  input logic [DATA_W-1:0]  wdata16,
  input logic [DATA_W-1:0]  rdata16
);
  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mdc_o && !mdio_oe_o));

  assert_start_by_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(reg_we_i));

  assert_preamble_driven_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> (mdio_oe_o && mdio_o));

  assert_rdata_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata16) |-> $fell(busy));

  assert_wlo_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_we_i && (reg_addr_i == OFS_WLO)) |=> $stable(wdata16[7:0]));
endmodule

bind mgmt_bridge mgmt_bridge_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .mdc_o      (mdc_o),
  .mdio_o     (mdio_o),
  .mdio_oe_o  (mdio_oe_o),
  .busy       (busy),
  .wdata16    (wdata16),
  .rdata16    (rdata16)
);

// File: tb/mgmt_bridge_tb.sv
`timescale 1ns/1ps
module mgmt_bridge_tb;
  import mgmt_bridge_pkg::*;

  localparam int H = 2;
  localparam logic [4:0] PHYA = 5'h05;
  localparam int FRAME_CYC = 128 * H;
  localparam int WD_CYC = 100000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       mdc, mdo, oe, mdi;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mgmt_bridge #(.PHY_ADDR(PHYA), .MDC_HALF(H)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdo),
    .mdio_oe_o(oe), .mdio_i(mdi));

  // behavioural reference model
  bit          m_act, m_rd;
  int          m_k;
  logic [63:0] m_frame;
  logic [4:0]  m_preg;
  logic [7:0]  m_wlo, m_whi;
  logic        m_cmd;
  logic [15:0] m_rdata;
  logic [15:0] phy_resp = 16'h0000;

  function automatic logic [63:0] mk_frame(bit rd, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), PHYA, r,
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act <= 0; m_rd <= 0; m_k <= 0; m_frame <= '1; m_preg <= 0;
      m_wlo <= 0; m_whi <= 0; m_cmd <= 0; m_rdata <= 0;
    end else begin
      if (m_act) begin
        if (m_k == FRAME_CYC - 1) begin
          m_act <= 0;
          if (m_rd) m_rdata <= phy_resp;
        end else m_k <= m_k + 1;
      end
      if (we) begin
        if (addr == OFS_PHYREG) m_preg <= wdata[4:0];
        if (!m_act) begin
          if (addr == OFS_CMD) begin
            m_cmd <= wdata[0];
            if (wdata[0]) begin
              m_act <= 1; m_rd <= 1; m_k <= 0;
              m_frame <= mk_frame(1'b1, m_preg, 16'h0);
            end
          end
          if (addr == OFS_WLO) m_wlo <= wdata;
          if (addr == OFS_WHI) begin
            m_whi <= wdata;
            m_act <= 1; m_rd <= 0; m_k <= 0;
            m_frame <= mk_frame(1'b0, m_preg, {wdata, m_wlo});
          end
        end
      end
    end
  end

  int m_idx;
  assign m_idx = m_k / (2 * H);
  // PHY model drives data bits of a read
  assign mdi = (m_act && m_rd && m_idx >= DATA_POS) ? phy_resp[63 - m_idx] : 1'b1;

  // per-clock comparison of the serial side
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic e_mdc, e_oe;
      e_mdc = m_act ? (((m_k / H) % 2) == 1) : 1'b0;
      e_oe  = m_act && !(m_rd && m_idx >= TA_POS);
      n_checks++;
      if (mdc !== e_mdc) begin
        n_fail++;
        $display("FAIL R5 mdc actual=%0b expected=%0b k=%0d", mdc, e_mdc, m_k);
      end
      n_checks++;
      if (oe !== e_oe) begin
        n_fail++;
        $display("FAIL R2/R3 oe actual=%0b expected=%0b k=%0d", oe, e_oe, m_k);
      end
      if (e_oe) begin
        n_checks++;
        if (mdo !== m_frame[63 - m_idx]) begin
          n_fail++;
          $display("FAIL R2/R3/R8 mdio actual=%0b expected=%0b bit=%0d", mdo,
                   m_frame[63 - m_idx], m_idx);
        end
      end
    end
  end

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    n_checks++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s offset %0d actual=%02h expected=%02h", tag, a, rdata, exp);
    end
  endtask

  task automatic wait_idle(output int n);
    n = 0; addr = OFS_STATUS; #1;
    while (rdata[0] === 1'b1) begin
      n++; @(negedge clk); #1;
    end
  endtask

  task automatic chk_val(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL R4 watchdog actual=%0d expected<%0d cycles", WD_CYC, WD_CYC);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state, R8 map
    for (int a = 0; a < 8; a++) chk_reg(3'(a), 8'h00, "R1 reset");

    // R2 read of register 0x12, R4 busy length, R6 capture
    host_write(OFS_PHYREG, 8'h12);
    phy_resp = 16'hA5C3;
    host_write(OFS_CMD, 8'h01);
    wait_idle(n);
    chk_val(n, FRAME_CYC, "R4 busy cycles read");
    chk_reg(OFS_RLO, 8'hC3, "R6 rdata lo");
    chk_reg(OFS_RHI, 8'hA5, "R6 rdata hi");
    chk_reg(OFS_CMD, 8'h01, "R8 cmd readback");
    host_write(OFS_CMD, 8'h00);
    chk_reg(OFS_CMD, 8'h00, "R8 cmd cleared");

    // R3 write frame, R7 ignored writes, R8 reg change mid-frame
    host_write(OFS_PHYREG, 8'h07);
    host_write(OFS_WLO, 8'h34);
    host_write(OFS_WHI, 8'h12);
    chk_reg(OFS_STATUS, 8'h01, "R4 busy after write start");
    host_write(OFS_WLO, 8'hFF);
    host_write(OFS_WHI, 8'h99);
    host_write(OFS_CMD, 8'h01);
    host_write(OFS_PHYREG, 8'h1F);
    chk_reg(OFS_WLO, 8'h34, "R7 wlo held while busy");
    chk_reg(OFS_WHI, 8'h12, "R7 whi held while busy");
    chk_reg(OFS_CMD, 8'h00, "R7 cmd held while busy");
    chk_reg(OFS_PHYREG, 8'h1F, "R8 phyreg write mid-frame");
    wait_idle(n);
    chk_reg(OFS_STATUS, 8'h00, "R7 no extra frame");
    chk_reg(OFS_RLO, 8'hC3, "R6 rdata held over write lo");
    chk_reg(OFS_RHI, 8'hA5, "R6 rdata held over write hi");

    // write with full-length cycle count
    host_write(OFS_WLO, 8'h00);
    host_write(OFS_WHI, 8'hFF);
    wait_idle(n);
    chk_val(n, FRAME_CYC, "R4 busy cycles write");

    // R7 clearing read bit during a read, all-ones data from register 0x1F
    phy_resp = 16'hFFFF;
    host_write(OFS_CMD, 8'h01);
    host_write(OFS_CMD, 8'h00);
    chk_reg(OFS_CMD, 8'h01, "R7 read bit held");
    wait_idle(n);
    chk_reg(OFS_RLO, 8'hFF, "R6 rdata ones lo");
    chk_reg(OFS_RHI, 8'hFF, "R6 rdata ones hi");
    host_write(OFS_CMD, 8'h00);

    // R2 read of register 0 returning zero
    host_write(OFS_PHYREG, 8'h00);
    phy_resp = 16'h0000;
    host_write(OFS_CMD, 8'h01);
    wait_idle(n);
    chk_reg(OFS_RLO, 8'h00, "R2 R6 rdata zero lo");
    chk_reg(OFS_RHI, 8'h00, "R2 R6 rdata zero hi");
    chk_reg(3'd7, 8'h00, "R8 unmapped");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule